// File: doc/BRIEF.md
# Saturating Signed Multiply-Accumulate

This block takes two signed operands on each valid strobe, forms their signed product and folds it into an accumulator. The accumulator is held as two equal halves, a high word and a low word. A mode input picks how the product is folded in for that strobe.

In wide mode the two halves act as one double-width register, and the sign-extended product is added to the full value. In clamping mode only the low word accumulates, as a signed value. A result that leaves the signed range of one word is pinned to the nearest limit, and the high word is then loaded with the value 1 to flag that the limit was hit.

A clear command empties both halves. The operands reach the block as values already read from memory. Fetching them and stepping any address pointers is the job of the surrounding pipeline.

Top module: `sat_mac`

## Requirements
- R1: While the synchronous active-low reset is asserted at a clock edge, both the high and the low word become 0.
- R2: When clear_i is 1 at a clock edge, both words become 0 on that edge, whatever valid_i, the mode and the operands are.
- R3: When clear_i and valid_i are both 0 at a clock edge, both words keep their values, whatever the mode and the operands are.
- R4: When valid_i is 1 and sat_mode_i is 0, the concatenation {high, low} takes ({high, low} + signed product sign-extended to double width) modulo 2^(2*HALFW) on that edge. Both operands are read as two's-complement values.
- R5: When valid_i is 1, sat_mode_i is 1 and (the low word read as signed + the signed product) lies within the signed HALFW-bit range, the low word takes that sum and the high word is unchanged.
- R6: In the same mode, if that sum is above the signed maximum, the low word becomes 2^(HALFW-1)-1 and the high word becomes 1.
- R7: In the same mode, if that sum is below the signed minimum, the low word becomes -2^(HALFW-1), encoded as a 1 in the top bit followed by zeros, and the high word becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clear_i | input | 1 | Zero both accumulator words; takes priority over valid_i |
| valid_i | input | 1 | Accumulate the product of the operands on this edge |
| sat_mode_i | input | 1 | 1 = clamping single-word mode, 0 = wide double-word mode |
| op_a_i | input | OPW | First operand, two's complement |
| op_b_i | input | OPW | Second operand, two's complement |
| acc_hi_o | output | HALFW | High accumulator word |
| acc_lo_o | output | HALFW | Low accumulator word |

## Verification
The bench builds the block with OPW = 4 and HALFW = 8. At that size every one of the 256 operand pairs can be driven in both modes. The 8-bit low word also overflows within a few strobes, so the positive clamp and the negative clamp are both reached, along with the carry and borrow between the two halves in wide mode. The operand sign handling, the limit detection and the overflow flag in the high word use the same logic at every width, so this small build covers the decisions that the 16-bit and 32-bit default build makes.

// File: rtl/sat_mac_pkg.sv
// Shared types for the saturating multiply-accumulate.
// Assumes nothing beyond the encoding of the mode input.
package sat_mac_pkg;
    typedef enum logic {
        ACC_WIDE  = 1'b0,
        ACC_CLAMP = 1'b1
    } acc_mode_e;
endpackage

// File: rtl/sat_mac_mult.sv
// Signed multiplier: forms the full-width two's-complement product.
// Assumes both operands are two's complement of width OPW.
module sat_mac_mult #(
    parameter int OPW = 16,
    localparam int PW = 2 * OPW
) (
    input  logic [OPW-1:0] op_a,
    input  logic [OPW-1:0] op_b,
    output logic [PW-1:0]  prod
);
    // Signed product of the two operands.
    always_comb begin
        prod = PW'($signed(op_a) * $signed(op_b));
    end
endmodule

// File: rtl/sat_mac_wide_add.sv
// Wide-mode adder: adds the sign-extended product to the double word.
// Assumes PW <= 2*HALFW.
module sat_mac_wide_add #(
    parameter int HALFW = 32,
    parameter int PW    = 32,
    localparam int AW   = 2 * HALFW
) (
    input  logic [HALFW-1:0] hi,
    input  logic [HALFW-1:0] lo,
    input  logic [PW-1:0]    prod,
    output logic [HALFW-1:0] hi_nxt,
    output logic [HALFW-1:0] lo_nxt
);
    logic [AW-1:0] sum;

    // Modular double-width sum split back into its halves.
    always_comb begin
        sum    = {hi, lo} + {{(AW-PW){prod[PW-1]}}, prod};
        hi_nxt = sum[AW-1:HALFW];
        lo_nxt = sum[HALFW-1:0];
    end
endmodule

// File: rtl/sat_mac_clamp_add.sv
// Clamp-mode adder: adds the product to the signed low word. An
// out-of-range result is pinned to the nearest limit and the high word
// is loaded with 1. Assumes PW <= HALFW.
module sat_mac_clamp_add #(
    parameter int HALFW = 32,
    parameter int PW    = 32,
    localparam int SW   = HALFW + 1
) (
    input  logic [HALFW-1:0] hi,
    input  logic [HALFW-1:0] lo,
    input  logic [PW-1:0]    prod,
    output logic [HALFW-1:0] hi_nxt,
    output logic [HALFW-1:0] lo_nxt
);
    localparam logic [HALFW-1:0] POS_LIM = {1'b0, {(HALFW-1){1'b1}}};
    localparam logic [HALFW-1:0] NEG_LIM = {1'b1, {(HALFW-1){1'b0}}};
    localparam logic [HALFW-1:0] MARK    = {{(HALFW-1){1'b0}}, 1'b1};

    logic [SW-1:0] sum;
    logic          pos_ovf;
    logic          neg_ovf;

    // One-bit-wider sum, so both overflow directions show in the top two bits.
    always_comb begin
        sum     = {lo[HALFW-1], lo} + {{(SW-PW){prod[PW-1]}}, prod};
        pos_ovf = !sum[SW-1] && sum[SW-2];
        neg_ovf = sum[SW-1] && !sum[SW-2];
    end

    // Select the sum, a limit and the overflow flag.
    always_comb begin
        if (pos_ovf) begin
            lo_nxt = POS_LIM;
            hi_nxt = MARK;
        end else if (neg_ovf) begin
            lo_nxt = NEG_LIM;
            hi_nxt = MARK;
        end else begin
            lo_nxt = sum[HALFW-1:0];
            hi_nxt = hi;
        end
    end
endmodule

// File: rtl/sat_mac.sv
// Saturating signed multiply-accumulate, top level. Multiplies two
// signed operands and folds the product into a two-word accumulator,
// either as one wide value or as a clamped signed low word.
// Assumes 2*OPW <= HALFW and operands already fetched.
module sat_mac #(
    parameter int OPW   = 16,
    parameter int HALFW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             valid_i,
    input  logic             sat_mode_i,
    input  logic [OPW-1:0]   op_a_i,
    input  logic [OPW-1:0]   op_b_i,
    output logic [HALFW-1:0] acc_hi_o,
    output logic [HALFW-1:0] acc_lo_o
);
    import sat_mac_pkg::*;

    localparam int PW = 2 * OPW;

    acc_mode_e        mode;
    logic [PW-1:0]    prod;
    logic [HALFW-1:0] wide_hi, wide_lo;
    logic [HALFW-1:0] clamp_hi, clamp_lo;
    logic [HALFW-1:0] acc_hi, acc_lo;

    assign mode = acc_mode_e'(sat_mode_i);

    sat_mac_mult #(.OPW(OPW)) mult_i (
        .op_a (op_a_i),
        .op_b (op_b_i),
        .prod (prod)
    );

    sat_mac_wide_add #(.HALFW(HALFW), .PW(PW)) wide_i (
        .hi     (acc_hi),
        .lo     (acc_lo),
        .prod   (prod),
        .hi_nxt (wide_hi),
        .lo_nxt (wide_lo)
    );

    sat_mac_clamp_add #(.HALFW(HALFW), .PW(PW)) clamp_i (
        .hi     (acc_hi),
        .lo     (acc_lo),
        .prod   (prod),
        .hi_nxt (clamp_hi),
        .lo_nxt (clamp_lo)
    );

    // Accumulator update: reset and clear first, then the selected mode.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            acc_hi <= '0;
            acc_lo <= '0;
        end else if (valid_i) begin
            if (mode == ACC_CLAMP) begin
                acc_hi <= clamp_hi;
                acc_lo <= clamp_lo;
            end else begin
                acc_hi <= wide_hi;
                acc_lo <= wide_lo;
            end
        end
    end

    assign acc_hi_o = acc_hi;
    assign acc_lo_o = acc_lo;
endmodule

// File: rtl/sat_mac_chk.sv
// Property checker for sat_mac, attached by bind. Watches ports only.
module sat_mac_chk #(
    parameter int OPW   = 16,
    parameter int HALFW = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear_i,
    input logic             valid_i,
    input logic             sat_mode_i,
    input logic [OPW-1:0]   op_a_i,
    input logic [OPW-1:0]   op_b_i,
    input logic [HALFW-1:0] acc_hi_o,
    input logic [HALFW-1:0] acc_lo_o
);
    localparam logic [HALFW-1:0] POS_LIM = {1'b0, {(HALFW-1){1'b1}}};
    localparam logic [HALFW-1:0] NEG_LIM = {1'b1, {(HALFW-1){1'b0}}};
    localparam logic [HALFW-1:0] MARK    = {{(HALFW-1){1'b0}}, 1'b1};

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (acc_hi_o == '0 && acc_lo_o == '0)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !valid_i) |=> ($stable(acc_hi_o) && $stable(acc_lo_o))); // R3

    AST_WIDE_ZERO_PROD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !clear_i && !sat_mode_i && (op_a_i == '0 || op_b_i == '0))
        |=> ($stable(acc_hi_o) && $stable(acc_lo_o))); // R4

    AST_CLAMP_HI_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !clear_i && sat_mode_i)
        |=> (acc_hi_o == $past(acc_hi_o) || acc_hi_o == MARK)); // R6

    AST_CLAMP_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !clear_i && sat_mode_i)
        |=> (acc_hi_o == $past(acc_hi_o) || acc_lo_o == POS_LIM
             || acc_lo_o == NEG_LIM)); // R7
endmodule

bind sat_mac sat_mac_chk #(.OPW(OPW), .HALFW(HALFW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear_i),
    .valid_i    (valid_i),
    .sat_mode_i (sat_mode_i),
    .op_a_i     (op_a_i),
    .op_b_i     (op_b_i),
    .acc_hi_o   (acc_hi_o),
    .acc_lo_o   (acc_lo_o)
);

// File: tb/sat_mac_tb_top.sv
// Sweep bench for sat_mac at OPW=4, HALFW=8 with an arithmetic model.
module sat_mac_tb_top;
    localparam int OPW = 4;
    localparam int HW  = 8;
    localparam int AW  = 2 * HW;
    localparam int OMIN = -(1 << (OPW - 1));
    localparam int OMAX = (1 << (OPW - 1)) - 1;
    localparam longint SMAX = (64'sd1 <<< (HW - 1)) - 1;
    localparam longint SMIN = -(64'sd1 <<< (HW - 1));

    logic clk = 1'b0;
    logic rst_n, clear_i, valid_i, sat_mode_i;
    logic [OPW-1:0] op_a_i, op_b_i;
    logic [HW-1:0]  acc_hi_o, acc_lo_o;
    logic [HW-1:0]  exp_hi, exp_lo;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sat_mac #(.OPW(OPW), .HALFW(HW)) dut_i (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .valid_i(valid_i),
        .sat_mode_i(sat_mode_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
        .acc_hi_o(acc_hi_o), .acc_lo_o(acc_lo_o)
    );

    task automatic check(input string tag);
        checks++;
        if (acc_hi_o !== exp_hi || acc_lo_o !== exp_lo) begin
            errors++;
            $display("FAIL %s hi=%0h lo=%0h expected hi=%0h lo=%0h",
                     tag, acc_hi_o, acc_lo_o, exp_hi, exp_lo);
        end
    endtask

    // Drive one cycle at a falling edge, update the model, compare at the next.
    task automatic step(input bit clr, input bit v, input bit sat,
                        input int a, input int b);
        string tag;
        longint p, s;
        logic [AW-1:0] w;
        clear_i = clr; valid_i = v; sat_mode_i = sat;
        op_a_i = a[OPW-1:0]; op_b_i = b[OPW-1:0];
        p = longint'(a) * longint'(b);
        if (clr) begin
            exp_hi = '0; exp_lo = '0; tag = "R2";
        end else if (!v) begin
            tag = "R3";
        end else if (!sat) begin
            w = {exp_hi, exp_lo} + AW'(p);
            exp_hi = w[AW-1:HW]; exp_lo = w[HW-1:0]; tag = "R4";
        end else begin
            s = longint'($signed(exp_lo)) + p;
            if (s > SMAX) begin
                exp_lo = HW'(SMAX); exp_hi = HW'(1); tag = "R6";
            end else if (s < SMIN) begin
                exp_lo = HW'(SMIN); exp_hi = HW'(1); tag = "R7";
            end else begin
                exp_lo = HW'(s); tag = "R5";
            end
        end
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; clear_i = 1'b0; valid_i = 1'b1; sat_mode_i = 1'b0;
        op_a_i = 4'h7; op_b_i = 4'h7;
        exp_hi = '0; exp_lo = '0;
        @(negedge clk); @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        step(0, 0, 0, 3, 3);
        // R4: every operand pair in wide mode
        for (int a = OMIN; a <= OMAX; a++)
            for (int b = OMIN; b <= OMAX; b++)
                step(0, 1, 0, a, b);
        // R4: carry into the high word, then borrow through zero
        for (int i = 0; i < 6; i++) step(0, 1, 0, OMIN, OMIN);
        for (int i = 0; i < 12; i++) step(0, 1, 0, OMIN, OMAX);
        // R3: idle with changing operands and mode
        for (int i = 0; i < 8; i++) step(0, 0, i % 2, i - 4, 7 - i);
        // R2: clear wins over a valid strobe
        step(1, 1, 1, OMIN, OMIN);
        // R5: clamping mode keeps a nonzero high word
        for (int i = 0; i < 5; i++) step(0, 1, 0, OMIN, OMIN);
        step(0, 1, 1, 1, -1);
        step(0, 1, 1, OMIN, OMAX);
        // R5 R6 R7: every operand pair in clamping mode
        step(1, 0, 0, 0, 0);
        for (int a = OMIN; a <= OMAX; a++)
            for (int b = OMIN; b <= OMAX; b++)
                step(0, 1, 1, a, b);
        // R7: drive the low word past the negative limit
        for (int i = 0; i < 6; i++) step(0, 1, 1, OMIN, OMAX);
        // R6: drive it past the positive limit
        for (int i = 0; i < 6; i++) step(0, 1, 1, OMIN, OMIN);
        // R5 R6 R7: pairs in clamping mode starting near the negative limit
        step(1, 0, 0, 0, 0);
        for (int i = 0; i < 2; i++) step(0, 1, 1, OMIN, OMAX);
        for (int b = OMAX; b >= OMIN; b--)
            for (int a = OMIN; a <= OMAX; a++)
                step(0, 1, 1, a, b);
        // R2: clear from a clamped state
        step(1, 0, 1, 0, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule